// File: doc/BRIEF.md
# UART Status Flag Controller

This block keeps the condition flags of a serial receiver and transmitter and shows them through a status register that the bus can read. The flags are frame error, noise error, overrun, idle line, receive word waiting, transmit finished and transmit holding register empty. Single-cycle strobes from the receive and transmit datapaths set the flags. Bus accesses clear them. The block also holds the received word and returns it when the data register is read.

The error flags cannot be cleared with one write. Software first reads the status register, which arms a small two-state sequencer. The next access to the data register then consumes that arm. If that access is a read, it clears the four error flags. If it is a write, it clears the transmit-finished flag. A data access without a status read before it clears none of these flags. Bus read data is combinational: it is valid in the same cycle as the access. Every flag change appears on the clock edge that ends the access or the strobe.

The sequencer has two states, `SEQ_IDLE` and `SEQ_ARMED`:
- `SEQ_IDLE` goes to `SEQ_ARMED` on a status read.
- `SEQ_ARMED` stays in `SEQ_ARMED` on a further status read.
- `SEQ_ARMED` goes back to `SEQ_IDLE` on any data-register read or write.

The receive holder has two states, `RX_EMPTY` and `RX_FULL`:
- `RX_EMPTY` goes to `RX_FULL` on a word push.
- `RX_FULL` goes back to `RX_EMPTY` on a data read or on a status write with bit 5 at 0, unless a push happens in the same cycle.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the status register reads 0x00C0: transmit-empty (bit 7) and transmit-finished (bit 6) are 1 and every other flag is 0. Bit 0 and bits 8 and above always read 0.
- R2: The status register is selected by `bus_sel`=0 and the data register by `bus_sel`=1. Read data for the selected register is valid in the same cycle. The received word is zero-extended.
- R3: A frame error strobe or a break strobe sets bit 1, a noise strobe sets bit 2, and an idle strobe sets bit 4. Each flag is visible from the next cycle.
- R4: Bits 1 to 4 clear only when a data read follows a status read. A status write of any value leaves them unchanged, and so does a data read with no status read before it.
- R5: A status read arms the clear sequence. Further status reads keep it armed. The next data access of either kind disarms it, and a data write clears no error flag.
- R6: A word push sets bit 5 and stores the word. Bit 5 clears on a data read or on a status write with bit 5 at 0. A status write with bit 5 at 1 has no effect.
- R7: A word push while bit 5 is 1 sets overrun (bit 3). The stored word is kept and bit 5 stays 1.
- R8: A transmit-load strobe sets bit 7. Any data write clears it.
- R9: A transmit-done strobe sets bit 6 only while bit 7 is 1. Bit 6 clears on a data write that follows a status read, or on a status write with bit 6 at 0. An unarmed data write, or a status write with bit 6 at 1, leaves it unchanged.
- R10: When a set strobe and a clearing access fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data of the selected register |
| hw_frame_err | input | 1 | Frame error seen by the receiver |
| hw_break | input | 1 | Break symbol received |
| hw_noise | input | 1 | Noise seen while sampling |
| hw_idle | input | 1 | Idle line detected |
| rx_push | input | 1 | Receiver hands over a complete word |
| rx_word | input | WORD_W | The received word |
| tx_pull | input | 1 | Transmit shifter takes the held word |
| tx_done | input | 1 | Last frame has finished shifting out |

## Verification
Read data is combinational, so the bench samples `bus_rdata` one time unit after it drives an access, before the clock edge. Every flag is a single register, so a strobe or access driven in one cycle shows its effect on the status read that starts in the following cycle. The bench drives on the falling edge and checks the next status read. Same-cycle collisions are driven together in one cycle and checked on the next read. Every status read arms the sequencer, so each scenario places a data read first whenever it needs the unarmed state.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
    // Status bit positions: software decodes these.
    localparam int FE_BIT   = 1;
    localparam int NE_BIT   = 2;
    localparam int ORE_BIT  = 3;
    localparam int IDLE_BIT = 4;
    localparam int RXNE_BIT = 5;
    localparam int TC_BIT   = 6;
    localparam int TXE_BIT  = 7;

    // Error flag slots inside the error bank.
    localparam int NUM_ERR  = 4;
    localparam int ERR_FE   = 0;
    localparam int ERR_NE   = 1;
    localparam int ERR_ORE  = 2;
    localparam int ERR_IDLE = 3;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    typedef enum logic [0:0] {
        RX_EMPTY = 1'b0,
        RX_FULL  = 1'b1
    } rx_state_t;
endpackage

// File: rtl/uart_flag_seq.sv
module uart_flag_seq
    import uart_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_rd,
    input  logic data_wr,
    output logic armed,
    output logic clr_err,
    output logic clr_tc
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE:  if (stat_rd) st_d = SEQ_ARMED;
            SEQ_ARMED: begin
                if (stat_rd)                st_d = SEQ_ARMED;
                else if (data_rd || data_wr) st_d = SEQ_IDLE;
            end
            default:   st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        armed   = (st_q == SEQ_ARMED);
        clr_err = armed && data_rd;
        clr_tc  = armed && data_wr;
    end
endmodule

// File: rtl/uart_flag_err.sv
module uart_flag_err #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
            else if (clr)       flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_flag_rx.sv
module uart_flag_rx
    import uart_flag_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] word,
    input  logic              drain,
    output logic              full,
    output logic              ovr_ev,
    output logic [WORD_W-1:0] data_q
);
    rx_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_EMPTY: if (push) st_d = RX_FULL;
            RX_FULL:  if (drain && !push) st_d = RX_EMPTY;
            default:  st_d = RX_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          data_q <= '0;
        else if (push && st_q == RX_EMPTY)   data_q <= word;
    end

    always_comb begin
        full   = (st_q == RX_FULL);
        ovr_ev = push && (st_q == RX_FULL);
    end
endmodule

// File: rtl/uart_flag_tx.sv
module uart_flag_tx (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic done,
    input  logic data_wr,
    input  logic clr_tc,
    output logic txe,
    output logic tc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       txe <= 1'b1;
        else if (load)    txe <= 1'b1;
        else if (data_wr) txe <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            tc <= 1'b1;
        else if (done && txe)  tc <= 1'b1;
        else if (clr_tc)       tc <= 1'b0;
    end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
    import uart_flag_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              hw_frame_err,
    input  logic              hw_break,
    input  logic              hw_noise,
    input  logic              hw_idle,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              tx_pull,
    input  logic              tx_done
);
    localparam int PAD_W = BUS_W - WORD_W;

    logic stat_rd, stat_wr, data_rd, data_wr;
    logic seq_armed, clr_err, clr_tc_seq;
    logic rx_full, ovr_ev;
    logic [WORD_W-1:0] rx_data_q;
    logic txe, tc;
    logic [NUM_ERR-1:0] err_set, err_q;
    logic [BUS_W-1:0] stat_word;
    logic wdata_unused;

    always_comb begin
        stat_rd = bus_rd && !bus_sel;
        stat_wr = bus_wr && !bus_sel;
        data_rd = bus_rd &&  bus_sel;
        data_wr = bus_wr &&  bus_sel;
    end

    assign wdata_unused = ^bus_wdata;

    uart_flag_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .data_wr (data_wr),
        .armed   (seq_armed),
        .clr_err (clr_err),
        .clr_tc  (clr_tc_seq)
    );

    uart_flag_rx #(.WORD_W(WORD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (rx_push),
        .word   (rx_word),
        .drain  (data_rd || (stat_wr && !bus_wdata[RXNE_BIT])),
        .full   (rx_full),
        .ovr_ev (ovr_ev),
        .data_q (rx_data_q)
    );

    always_comb begin
        err_set           = '0;
        err_set[ERR_FE]   = hw_frame_err || hw_break;
        err_set[ERR_NE]   = hw_noise;
        err_set[ERR_ORE]  = ovr_ev;
        err_set[ERR_IDLE] = hw_idle;
    end

    uart_flag_err #(.N(NUM_ERR)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (err_set),
        .clr    (clr_err),
        .flags  (err_q)
    );

    uart_flag_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tx_pull),
        .done    (tx_done),
        .data_wr (data_wr),
        .clr_tc  (clr_tc_seq || (stat_wr && !bus_wdata[TC_BIT])),
        .txe     (txe),
        .tc      (tc)
    );

    always_comb begin
        stat_word           = '0;
        stat_word[FE_BIT]   = err_q[ERR_FE];
        stat_word[NE_BIT]   = err_q[ERR_NE];
        stat_word[ORE_BIT]  = err_q[ERR_ORE];
        stat_word[IDLE_BIT] = err_q[ERR_IDLE];
        stat_word[RXNE_BIT] = rx_full;
        stat_word[TC_BIT]   = tc;
        stat_word[TXE_BIT]  = txe;
    end

    always_comb begin
        if (bus_sel) bus_rdata = {{PAD_W{1'b0}}, rx_data_q};
        else         bus_rdata = stat_word;
    end
endmodule

// File: rtl/uart_flag_chk.sv
module uart_flag_chk #(
    parameter int BUS_W  = 16,
    parameter int WORD_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              hw_frame_err,
    input logic              hw_break,
    input logic              hw_idle,
    input logic              rx_push,
    input logic              tx_pull,
    input logic              tx_done,
    input logic              armed,
    input logic [BUS_W-1:0]  status,
    input logic [WORD_W-1:0] rx_data
);
    // R3
    fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_frame_err || hw_break) |=> status[1]);

    // R4
    fe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !(armed && bus_rd && bus_sel)) |=> status[1]);

    // R5
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_sel) |=> armed);

    // R6
    rxne_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> status[5]);

    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && status[5]) |=> (status[3] && status[5] && rx_data == $past(rx_data)));

    // R8
    txe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && !tx_pull) |=> !status[7]);

    // R9
    tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && status[7]) |=> status[6]);

    // R10
    idle_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_idle |=> status[4]);
endmodule

bind uart_flag_ctrl uart_flag_chk #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .hw_frame_err (hw_frame_err),
    .hw_break     (hw_break),
    .hw_idle      (hw_idle),
    .rx_push      (rx_push),
    .tx_pull      (tx_pull),
    .tx_done      (tx_done),
    .armed        (seq_armed),
    .status       (stat_word),
    .rx_data      (rx_data_q)
);

// File: tb/sim_uart_flag_ctrl.sv
module sim_uart_flag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W = 16;
    localparam int WORD_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [BUS_W-1:0] bus_wdata = '0;
    logic [BUS_W-1:0] bus_rdata;
    logic hw_frame_err = 1'b0, hw_break = 1'b0, hw_noise = 1'b0, hw_idle = 1'b0;
    logic rx_push = 1'b0;
    logic [WORD_W-1:0] rx_word = '0;
    logic tx_pull = 1'b0, tx_done = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [BUS_W-1:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_flag_ctrl #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u0 (.*);

    task automatic check(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; strobes set before the call are cleared after the edge.
    task automatic cyc(input logic rd, input logic wr, input logic sel,
                       input logic [BUS_W-1:0] wd, output logic [BUS_W-1:0] rv);
        bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_wdata = wd;
        #1 rv = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
        hw_frame_err = 1'b0; hw_break = 1'b0; hw_noise = 1'b0; hw_idle = 1'b0;
        rx_push = 1'b0; tx_pull = 1'b0; tx_done = 1'b0;
    endtask

    task automatic stat_rd(output logic [BUS_W-1:0] rv);
        cyc(1'b1, 1'b0, 1'b0, '0, rv);
    endtask

    task automatic data_rd(output logic [BUS_W-1:0] rv);
        cyc(1'b1, 1'b0, 1'b1, '0, rv);
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [BUS_W-1:0] e;
        logic [WORD_W-1:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        stat_rd(v); check("R1 reset status", v, 16'h00C0);
        data_rd(v); check("R2 reset data", v, 16'h0000);

        // Sweep every combination of error strobes (R3, R4, R5)
        for (int m = 1; m < 16; m++) begin
            data_rd(v);
            hw_frame_err = m[0]; hw_break = m[1]; hw_noise = m[2]; hw_idle = m[3];
            cyc(1'b0, 1'b0, 1'b0, '0, v);
            e = 16'h00C0;
            e[1] = m[0] | m[1]; e[2] = m[2]; e[4] = m[3];
            cyc(1'b0, 1'b1, 1'b0, 16'hFFE1, v);
            data_rd(v);
            stat_rd(v); check("R3 R4 set, unarmed read and status write ignored", v, e);
            stat_rd(v); check("R5 repeat status read", v, e);
            data_rd(v);
            stat_rd(v); check("R4 armed data read clears", v, 16'h00C0);
        end

        // R5: armed data write consumes arm without clearing errors
        data_rd(v);
        hw_frame_err = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        stat_rd(v);
        cyc(1'b0, 1'b1, 1'b1, 16'h0055, v);
        stat_rd(v); check("R5 R8 R9 write consumes arm", v, 16'h0002);
        data_rd(v);
        stat_rd(v); check("R4 clear after rearm", v, 16'h0000);

        // R9: done ignored while txe=0
        data_rd(v);
        tx_done = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        stat_rd(v); check("R9 done ignored without txe", v, 16'h0000);
        tx_pull = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        stat_rd(v); check("R8 load sets txe", v, 16'h0080);
        tx_done = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        stat_rd(v); check("R9 done sets tc", v, 16'h00C0);
        cyc(1'b0, 1'b1, 1'b0, 16'hFFFF, v);
        stat_rd(v); check("R9 write one keeps tc", v, 16'h00C0);
        cyc(1'b0, 1'b1, 1'b0, 16'h0000, v);
        stat_rd(v); check("R9 write zero clears tc", v, 16'h0080);
        tx_done = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        data_rd(v);
        data_rd(v);
        cyc(1'b0, 1'b1, 1'b1, 16'h0000, v);
        stat_rd(v); check("R8 R9 unarmed write", v, 16'h0040);

        // R2 R6: receive words
        for (int k = 0; k < 6; k++) begin
            w = WORD_W'((k * 171 + 1) ^ (k << 5));
            data_rd(v);
            rx_word = w; rx_push = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
            stat_rd(v); check("R6 push sets rxne", v, 16'h0060);
            data_rd(v); check("R2 R6 data word", v, BUS_W'(w));
            stat_rd(v); check("R6 data read clears rxne", v, 16'h0040);
        end

        // R7: overrun
        data_rd(v);
        rx_word = 9'h0A5; rx_push = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        rx_word = 9'h15A; rx_push = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        stat_rd(v); check("R7 overrun flag", v, 16'h0068);
        data_rd(v); check("R7 first word kept", v, 16'h00A5);
        stat_rd(v); check("R7 cleared by sequence", v, 16'h0040);

        // R6: write zero clears rxne, write one does not
        data_rd(v);
        rx_word = 9'h1C3; rx_push = 1'b1; cyc(1'b0, 1'b0, 1'b0, '0, v);
        cyc(1'b0, 1'b1, 1'b0, 16'hFFFF, v);
        stat_rd(v); check("R6 write one keeps rxne", v, 16'h0060);
        cyc(1'b0, 1'b1, 1'b0, 16'h0000, v);
        stat_rd(v); check("R6 R9 write zero clears", v, 16'h0000);
        data_rd(v); check("R6 word stays after clear", v, 16'h01C3);

        // R10: set wins over same-cycle clear
        stat_rd(v); check("R10 baseline", v, 16'h0000);
        hw_idle = 1'b1; data_rd(v);
        stat_rd(v); check("R10 idle beats clear", v, 16'h0010);
        data_rd(v);
        rx_word = 9'h033; rx_push = 1'b1; data_rd(v); check("R10 old word on collide", v, 16'h01C3);
        stat_rd(v); check("R10 rxne beats read", v, 16'h0020);
        data_rd(v); check("R10 new word", v, 16'h0033);
        tx_pull = 1'b1; cyc(1'b0, 1'b1, 1'b1, '0, v);
        stat_rd(v); check("R10 txe beats write", v, 16'h0080);
        tx_done = 1'b1; cyc(1'b0, 1'b1, 1'b0, 16'h0000, v);
        stat_rd(v); check("R10 tc beats write zero", v, 16'h00C0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule